// File: doc/BRIEF.md
# Double-Buffered Dual DAC Register Front End

This block is the host-facing register layer of an analog-output module that carries one or two 16-bit converter channels. A byte-wide write bus loads the low and high bytes of a channel's next code into a holding register. A separate strobe access then copies the held word into the active code register that drives the converter. Because of this double buffering, a partly written code never reaches the analog side.

Two kinds of strobe exist. Each channel has its own strobe address. A shared strobe address moves both channels' held codes into their active registers on the same clock edge, so the two outputs change together. An identification register tells software how many channels are fitted. The `NUM_CH` parameter selects the one-channel or two-channel build.

Codes are two's complement, so 0x0000 is mid-scale. The expected host sequence for a channel is: low byte, then high byte, then strobe. Every strobe raises a one-clock update pulse for each channel it loads.

Top module: `dual_dac_frontend`

## Requirements
- R1: While reset is asserted, and after it is released, both active codes and both holding registers read 0x0000 and both update pulses are low. A strobe issued right after reset therefore loads 0x0000.
- R2: For channel x, a write to 0x0D + 8*x stores the data byte into bits 7:0 of that channel's holding register, and a write to 0x0E + 8*x stores it into bits 15:8.
- R3: A write to a holding register leaves that channel's active code unchanged.
- R4: For channel x, a write of any data value to 0x0B + 8*x copies the holding register into the active code at that clock edge, and leaves the other channel's active code unchanged.
- R5: A write to 0x1B loads both channels' active codes from their holding registers on the same edge and raises both update pulses in the same cycle.
- R6: A channel's update pulse is high for exactly the one cycle after a strobe write that loads that channel, and low otherwise.
- R7: A read with address 0x00 returns 0xE3 in the two-channel build and 0xE2 in the one-channel build. A read of any other address returns 0x00. The read data appears in the cycle after the read request and holds until the next read.
- R8: In the one-channel build, writes to channel-1 addresses (0x13, 0x15, 0x16) have no effect. Channel-1 code stays 0x0000, its update pulse stays low, and the shared strobe loads channel 0 only.
- R9: A strobe leaves the holding register unchanged, so a later strobe with no new byte writes loads the same code again.
- R10: Writes to addresses that decode to no register (including 0x00) change no code and raise no update pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W | Register offset for a read or write |
| bus_wr | input | 1 | Write request for one cycle |
| bus_wdata | input | 8 | Write data byte |
| bus_rd | input | 1 | Read request for one cycle |
| bus_rdata | output | 8 | Read data, valid from the cycle after the request |
| dac_code0 | output | 16 | Active two's complement code, channel 0 |
| dac_code1 | output | 16 | Active two's complement code, channel 1 |
| dac_upd0 | output | 1 | One-cycle update pulse, channel 0 |
| dac_upd1 | output | 1 | One-cycle update pulse, channel 1 |

## Verification
- A holding-register byte is captured on the edge that samples the write. It can only be observed through a later strobe.
- An active code and its update pulse both change on the edge that samples the strobe, so they are valid in the very next cycle. Read data follows its request by one cycle.
- The bench drives every request on a falling edge and checks the outputs on the following falling edge. Each vector therefore sees exactly one rising edge.
- The bench runs a two-channel and a one-channel instance on the same bus, so each stimulus checks the fitted-channel rules against both builds.

// File: rtl/dac_fe_pkg.sv
package dac_fe_pkg;
  localparam int MAX_CH      = 2;
  localparam int CH_STRIDE   = 8;
  localparam int STRB_BASE   = 8'h0B;
  localparam int LSB_BASE    = 8'h0D;
  localparam int MSB_BASE    = 8'h0E;
  localparam int COMMON_STRB = 8'h1B;
  localparam int ID_ADDR     = 8'h00;
  localparam logic [7:0] ID_ONE_CH = 8'hE2;
  localparam logic [7:0] ID_TWO_CH = 8'hE3;

  function automatic logic [7:0] strb_addr(input int ch);
    return 8'(STRB_BASE + CH_STRIDE * ch);
  endfunction

  function automatic logic [7:0] lsb_addr(input int ch);
    return 8'(LSB_BASE + CH_STRIDE * ch);
  endfunction

  function automatic logic [7:0] msb_addr(input int ch);
    return 8'(MSB_BASE + CH_STRIDE * ch);
  endfunction
endpackage

// File: rtl/dac_addr_decode.sv
module dac_addr_decode #(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 8
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  output logic [dac_fe_pkg::MAX_CH-1:0] lsb_we,
  output logic [dac_fe_pkg::MAX_CH-1:0] msb_we,
  output logic [dac_fe_pkg::MAX_CH-1:0] strobe
);
  import dac_fe_pkg::*;

  logic common_hit;
  assign common_hit = (addr == ADDR_W'(COMMON_STRB));

  for (genvar x = 0; x < MAX_CH; x++) begin : g_ch
    if (x < NUM_CH) begin : g_fitted
      assign lsb_we[x] = wr_en && (addr == ADDR_W'(lsb_addr(x)));
      assign msb_we[x] = wr_en && (addr == ADDR_W'(msb_addr(x)));
      assign strobe[x] = wr_en && ((addr == ADDR_W'(strb_addr(x))) || common_hit);
    end else begin : g_absent
      assign lsb_we[x] = 1'b0;
      assign msb_we[x] = 1'b0;
      assign strobe[x] = 1'b0;
    end
  end
endmodule

// File: rtl/dac_channel.sv
module dac_channel #(
  parameter int BYTE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  lsb_we,
  input  logic                  msb_we,
  input  logic                  strobe,
  input  logic [BYTE_W-1:0]     wr_data,
  output logic [2*BYTE_W-1:0]   code,
  output logic                  update
);
  localparam int DATA_W = 2 * BYTE_W;

  logic [DATA_W-1:0] hold_q, hold_d;
  logic [DATA_W-1:0] code_q, code_d;
  logic              upd_q, upd_d;
  logic              hold_en, code_en;

  always_comb begin
    hold_en = lsb_we || msb_we;
    hold_d  = hold_q;
    if (lsb_we) hold_d[BYTE_W-1:0]      = wr_data;
    if (msb_we) hold_d[DATA_W-1:BYTE_W] = wr_data;
    code_en = strobe;
    code_d  = hold_q;
    upd_d   = strobe;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      code_q <= '0;
      upd_q  <= 1'b0;
    end else begin
      if (hold_en) hold_q <= hold_d;
      if (code_en) code_q <= code_d;
      upd_q <= upd_d;
    end
  end

  assign code   = code_q;
  assign update = upd_q;

  // R3: loading a holding byte alone never moves the active code
  a_r3_hold_isolated: assert property (@(posedge clk) disable iff (!rst_n)
    ((lsb_we || msb_we) && !strobe) |=> $stable(code_q));

  // R4: a strobe loads the word that was held before the edge
  a_r4_strobe_loads: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> (code_q == $past(hold_q)));

  // R6: the update pulse follows a strobe by exactly one cycle
  a_r6_pulse_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(upd_q) |-> $past(strobe));

  a_r6_pulse_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> !upd_q);

  // R9: a strobe leaves the holding word untouched
  a_r9_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !lsb_we && !msb_we) |=> $stable(hold_q));
endmodule

// File: rtl/dual_dac_frontend.sv
module dual_dac_frontend #(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_rd,
  output logic [7:0]        bus_rdata,
  output logic [15:0]       dac_code0,
  output logic [15:0]       dac_code1,
  output logic              dac_upd0,
  output logic              dac_upd1
);
  import dac_fe_pkg::*;

  localparam int BYTE_W = 8;
  localparam int DATA_W = 2 * BYTE_W;
  localparam logic [7:0] ID_VALUE = (NUM_CH >= 2) ? ID_TWO_CH : ID_ONE_CH;

  // reset: asserted at once, released through two flops
  logic rst_s1_q, rst_s2_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  logic [MAX_CH-1:0] lsb_we, msb_we, strobe;

  dac_addr_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_decode (
    .wr_en  (bus_wr),
    .addr   (bus_addr),
    .lsb_we (lsb_we),
    .msb_we (msb_we),
    .strobe (strobe)
  );

  logic [DATA_W-1:0] code_w [MAX_CH];
  logic [MAX_CH-1:0] upd_w;

  for (genvar x = 0; x < MAX_CH; x++) begin : g_chan
    if (x < NUM_CH) begin : g_fitted
      dac_channel #(.BYTE_W(BYTE_W)) u_chan (
        .clk     (clk),
        .rst_n   (rst_s2_q),
        .lsb_we  (lsb_we[x]),
        .msb_we  (msb_we[x]),
        .strobe  (strobe[x]),
        .wr_data (bus_wdata),
        .code    (code_w[x]),
        .update  (upd_w[x])
      );
    end else begin : g_absent
      assign code_w[x] = '0;
      assign upd_w[x]  = 1'b0;
    end
  end

  // read port: one-cycle latency, holds between reads
  logic [7:0] rdata_q, rdata_d;
  logic       rd_en;

  always_comb begin
    rd_en   = bus_rd;
    rdata_d = (bus_addr == ADDR_W'(ID_ADDR)) ? ID_VALUE : 8'h00;
  end

  always_ff @(posedge clk or negedge rst_s2_q) begin
    if (!rst_s2_q) rdata_q <= 8'h00;
    else if (rd_en) rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;
  assign dac_code0 = code_w[0];
  assign dac_code1 = code_w[1];
  assign dac_upd0  = upd_w[0];
  assign dac_upd1  = upd_w[1];

  // R1: outputs are idle while the internal reset is held
  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_s2_q |-> (dac_code0 == '0 && dac_code1 == '0 && !dac_upd0 && !dac_upd1));

  // R5: the shared strobe raises both fitted pulses together
  a_r5_common_both: assert property (@(posedge clk) disable iff (!rst_s2_q)
    (bus_wr && bus_addr == ADDR_W'(COMMON_STRB)) |=> (dac_upd0 && (dac_upd1 || NUM_CH < 2)));

  // R7: identification read returns the build's code next cycle
  a_r7_id_read: assert property (@(posedge clk) disable iff (!rst_s2_q)
    (bus_rd && bus_addr == ADDR_W'(ID_ADDR)) |=> (bus_rdata == ID_VALUE));

  // R8: channel 1 stays idle when only one channel is fitted
  a_r8_absent_idle: assert property (@(posedge clk) disable iff (!rst_s2_q)
    (NUM_CH < 2) |-> (dac_code1 == '0 && !dac_upd1));

  // R10: an unmapped write raises no pulse
  a_r10_unmapped: assert property (@(posedge clk) disable iff (!rst_s2_q)
    (bus_wr && bus_addr == ADDR_W'(ID_ADDR)) |=> (!dac_upd0 && !dac_upd1));
endmodule

// File: tb/dual_dac_frontend_bench.sv
module dual_dac_frontend_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [7:0]  a;
    logic [7:0]  d;
    logic [15:0] c0;
    logic [15:0] c1;
    logic        u0;
    logic        u1;
    logic [15:0] s0;
    logic        su;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{8'h0D, 8'h34, 16'h0000, 16'h0000, 1'b0, 1'b0, 16'h0000, 1'b0},
    '{8'h0E, 8'h12, 16'h0000, 16'h0000, 1'b0, 1'b0, 16'h0000, 1'b0},
    '{8'h0B, 8'hA5, 16'h1234, 16'h0000, 1'b1, 1'b0, 16'h1234, 1'b1},
    '{8'h15, 8'hCD, 16'h1234, 16'h0000, 1'b0, 1'b0, 16'h1234, 1'b0},
    '{8'h16, 8'hAB, 16'h1234, 16'h0000, 1'b0, 1'b0, 16'h1234, 1'b0},
    '{8'h13, 8'h00, 16'h1234, 16'hABCD, 1'b0, 1'b1, 16'h1234, 1'b0},
    '{8'h0D, 8'hFF, 16'h1234, 16'hABCD, 1'b0, 1'b0, 16'h1234, 1'b0},
    '{8'h0E, 8'h80, 16'h1234, 16'hABCD, 1'b0, 1'b0, 16'h1234, 1'b0},
    '{8'h1B, 8'h00, 16'h80FF, 16'hABCD, 1'b1, 1'b1, 16'h80FF, 1'b1},
    '{8'h0B, 8'h00, 16'h80FF, 16'hABCD, 1'b1, 1'b0, 16'h80FF, 1'b1},
    '{8'h1F, 8'h77, 16'h80FF, 16'hABCD, 1'b0, 1'b0, 16'h80FF, 1'b0},
    '{8'h0C, 8'h55, 16'h80FF, 16'hABCD, 1'b0, 1'b0, 16'h80FF, 1'b0},
    '{8'h14, 8'h99, 16'h80FF, 16'hABCD, 1'b0, 1'b0, 16'h80FF, 1'b0},
    '{8'h15, 8'h01, 16'h80FF, 16'hABCD, 1'b0, 1'b0, 16'h80FF, 1'b0},
    '{8'h16, 8'h00, 16'h80FF, 16'hABCD, 1'b0, 1'b0, 16'h80FF, 1'b0},
    '{8'h13, 8'h3C, 16'h80FF, 16'h0001, 1'b0, 1'b1, 16'h80FF, 1'b0},
    '{8'h0E, 8'h7F, 16'h80FF, 16'h0001, 1'b0, 1'b0, 16'h80FF, 1'b0},
    '{8'h1B, 8'hEE, 16'h7FFF, 16'h0001, 1'b1, 1'b1, 16'h7FFF, 1'b1},
    '{8'h00, 8'h5A, 16'h7FFF, 16'h0001, 1'b0, 1'b0, 16'h7FFF, 1'b0}
  };

  logic        clk;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_wr;
  logic [7:0]  bus_wdata;
  logic        bus_rd;
  logic [7:0]  rdata2, rdata1;
  logic [15:0] code0, code1, s_code0, s_code1;
  logic        upd0, upd1, s_upd0, s_upd1;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  dual_dac_frontend #(.NUM_CH(2), .ADDR_W(8)) u_dual_dac_frontend (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(rdata2),
    .dac_code0(code0), .dac_code1(code1), .dac_upd0(upd0), .dac_upd1(upd1)
  );

  dual_dac_frontend #(.NUM_CH(1), .ADDR_W(8)) u_single (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(rdata1),
    .dac_code0(s_code0), .dac_code1(s_code1), .dac_upd0(s_upd0), .dac_upd1(s_upd1)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_wr(input logic [7:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic do_rd(input logic [7:0] a);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle_check(input string tag);
    chk({tag, " code0"}, code0, 16'h0000);
    chk({tag, " code1"}, code1, 16'h0000);
    chk({tag, " upd"}, {14'd0, upd0, upd1}, 16'h0000);
    chk({tag, " single code0"}, s_code0, 16'h0000);
    chk({tag, " single upd"}, {15'd0, s_upd0}, 16'h0000);
  endtask

  initial begin
    rst_n = 1'b0; bus_addr = 8'h00; bus_wr = 1'b0; bus_wdata = 8'h00; bus_rd = 1'b0;
    repeat (3) @(negedge clk);
    idle_check("R1 in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    idle_check("R1 after release");

    // R7: identification reads, one cycle latency
    do_rd(8'h00);
    chk("R7 id two-channel", {8'h00, rdata2}, 16'h00E3);
    chk("R7 id one-channel", {8'h00, rdata1}, 16'h00E2);
    @(negedge clk);
    chk("R7 read data holds", {8'h00, rdata2}, 16'h00E3);
    do_rd(8'h0B);
    chk("R7 other address reads zero", {8'h00, rdata2}, 16'h0000);

    // R2 R3 R4 R5 R6 R8 R9 R10 vector walk
    for (int i = 0; i < NV; i++) begin
      do_wr(VECS[i].a, VECS[i].d);
      chk($sformatf("R2/R3/R4/R5/R9/R10 vec%0d code0", i), code0, VECS[i].c0);
      chk($sformatf("R2/R4/R5 vec%0d code1", i), code1, VECS[i].c1);
      chk($sformatf("R6 vec%0d upd0", i), {15'd0, upd0}, {15'd0, VECS[i].u0});
      chk($sformatf("R6 vec%0d upd1", i), {15'd0, upd1}, {15'd0, VECS[i].u1});
      chk($sformatf("R8 vec%0d single code0", i), s_code0, VECS[i].s0);
      chk($sformatf("R8 vec%0d single upd0", i), {15'd0, s_upd0}, {15'd0, VECS[i].su});
      chk($sformatf("R8 vec%0d single code1", i), s_code1, 16'h0000);
      chk($sformatf("R8 vec%0d single upd1", i), {15'd0, s_upd1}, 16'h0000);
    end

    // R6: pulse gone after one idle cycle
    @(negedge clk);
    chk("R6 pulse ends upd0", {15'd0, upd0}, 16'h0000);
    chk("R6 pulse ends upd1", {15'd0, upd1}, 16'h0000);

    // R1: asynchronous reset mid-run clears codes and holding words
    rst_n = 1'b0;
    #1;
    chk("R1 async clear code0", code0, 16'h0000);
    chk("R1 async clear code1", code1, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    do_wr(8'h1B, 8'h00);
    chk("R1 holding cleared code0", code0, 16'h0000);
    chk("R1 holding cleared code1", code1, 16'h0000);
    chk("R5 both pulses after reset", {14'd0, upd0, upd1}, 16'h0003);
    chk("R8 shared strobe single", {14'd0, s_upd0, s_upd1}, 16'h0002);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule